// File: doc/BRIEF.md
# Programmable Baud-Rate Clock Generator

This block derives a serial baud clock from one of three sources: an always-on internal reference or either of two external clock inputs. The chosen source can be divided by 16 first, which makes slow rates reachable from a fast reference. The result then passes through a divider with a 12-bit programmable divisor. Everything runs on the system clock. Each external clock is sampled and turned into a one-cycle source tick. The block drives two outputs: a square-wave baud clock, meant for a pin and for clock routing to serial controllers, and a one-cycle tick strobe that marks each period boundary.

Software may change the divisor, the divide-by-16 choice and the source while the generator runs. The block holds each new setting in a staging point and applies it only when the current period ends, so no shortened or stretched output pulse appears. When autobaud is on, a synchronised falling edge on the receive-data line restarts the prescaler and the divider. This aligns the output phase to a start bit.

Top module: `baud_clkgen`

## Requirements
- R1: The source select chooses the source tick. 2'b00 and 2'b11 select the internal reference, which gives a tick on every enabled cycle. 2'b01 selects external input A and 2'b10 selects external input B.
- R2: Each rising edge on the selected external input produces exactly one source tick. The edge passes through two synchronising flops and an edge detector, provided each level is held for at least two system clock cycles.
- R3: With the prescaler off, baud_tick_o pulses once every (cfg_div + 1) source ticks. A divisor of 0 divides by 1 and a divisor of 4095 divides by 4096.
- R4: With cfg_pre16 set, the source ticks are first divided by 16, so one output period spans 16 × (cfg_div + 1) source ticks.
- R5: baud_tick_o is high for the single cycle after each terminal count, and baud_clk_o toggles on the same clock edge. The output clock is therefore a square wave at half the tick rate.
- R6: Changes to the divisor, prescale and source settings made while the block runs take effect only at the next terminal count. The period in progress completes with the old settings.
- R7: While cfg_autobaud is set, a synchronised falling edge on rxd clears the prescaler and the divider, drives baud_clk_o low and suppresses the tick. The next tick then follows a full period counted from the restart. rxd reaches the restart three clock edges after it falls.
- R8: While cfg_autobaud is clear, rxd has no effect on either output.
- R9: While cfg_en is low, both outputs are low one cycle later, the counters are cleared and the settings are loaded directly. After enable rises, the first tick arrives after one full period.
- R10: After reset both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Generator enable |
| cfg_src_sel | input | 2 | Source select (see R1) |
| cfg_pre16 | input | 1 | Divide-by-16 prescale enable |
| cfg_div | input | 12 | Divisor; ratio is value + 1 |
| cfg_autobaud | input | 1 | Let rxd start-bit edges restart the generator |
| rxd | input | 1 | Receive-data line, idle high |
| ext_clk_a | input | 1 | External clock input A |
| ext_clk_b | input | 1 | External clock input B |
| baud_clk_o | output | 1 | Generated square-wave baud clock |
| baud_tick_o | output | 1 | One-cycle strobe at each terminal count |

## Verification
The divider is driven from the internal reference with divisors of 0, 5 and 4095. These runs separate an off-by-one in the ratio from an error at the width limit. It is also driven from two external inputs with different toggle rates, and with the prescaler on, which distinguishes a wrong source mux from a wrong prescale count. The divisor is rewritten right after a tick to show that the old period still finishes. rxd is pulled low with autobaud on and with autobaud off, which separates a working restart from one that leaks through. A behavioural model tracks both outputs on every cycle throughout.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    typedef enum logic [1:0] {
        SRC_REF     = 2'b00,
        SRC_EXT_A   = 2'b01,
        SRC_EXT_B   = 2'b10,
        SRC_REF_ALT = 2'b11
    } src_e;
endpackage

// File: rtl/bcg_sync_edge.sv
module bcg_sync_edge #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0,
    parameter bit   FALLING   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_o
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {SH_W{RESET_VAL}};
        else        sh_q <= sh_d;
    end

    generate
        if (FALLING) begin : g_fall
            assign edge_o = ~sh_q[STAGES-1] & sh_q[STAGES];
        end else begin : g_rise
            assign edge_o = sh_q[STAGES-1] & ~sh_q[STAGES];
        end
    endgenerate
endmodule

// File: rtl/bcg_prescale.sv
module bcg_prescale #(
    parameter int PRE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic pre_on,
    input  logic src_tick,
    output logic pre_tick
);
    logic [PRE_W-1:0] cnt_d, cnt_q;

    assign pre_tick = src_tick & (~pre_on | (&cnt_q));

    always_comb begin
        cnt_d = cnt_q;
        if (clr || !pre_on)  cnt_d = '0;
        else if (src_tick)   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bcg_divider.sv
module bcg_divider #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             pre_tick,
    input  logic [DIV_W-1:0] div_val,
    output logic             terminal,
    output logic             clk_o,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             oclk;
        logic             tick;
    } div_st_t;

    div_st_t st_d, st_q;

    assign terminal = pre_tick && (st_q.cnt == div_val);

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (pre_tick) st_d.cnt = terminal ? '0 : st_q.cnt + 1'b1;
            st_d.tick = terminal;
            st_d.oclk = st_q.oclk ^ terminal;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clk_o  = st_q.oclk;
    assign tick_o = st_q.tick;
endmodule

// File: rtl/baud_clkgen.sv
module baud_clkgen #(
    parameter int DIV_W       = 12,
    parameter int PRE_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic [1:0]       cfg_src_sel,
    input  logic             cfg_pre16,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_autobaud,
    input  logic             rxd,
    input  logic             ext_clk_a,
    input  logic             ext_clk_b,
    output logic             baud_clk_o,
    output logic             baud_tick_o
);
    import bcg_pkg::*;

    localparam int N_EXT = 2;

    typedef struct packed {
        src_e             src;
        logic             pre;
        logic [DIV_W-1:0] div;
    } act_t;

    act_t act_d, act_q;

    logic [N_EXT-1:0] ext_in, ext_rise;
    logic             rx_fall, restart, clr, load;
    logic             src_tick, pre_tick, terminal;
    logic [1:0]       act_src;
    logic             act_pre;
    logic [DIV_W-1:0] act_div;

    assign ext_in = {ext_clk_b, ext_clk_a};

    generate
        for (genvar i = 0; i < N_EXT; i++) begin : g_ext
            bcg_sync_edge #(
                .STAGES(SYNC_STAGES), .RESET_VAL(1'b0), .FALLING(1'b0)
            ) u_sync (
                .clk(clk), .rst_n(rst_n), .din(ext_in[i]), .edge_o(ext_rise[i])
            );
        end
    endgenerate

    bcg_sync_edge #(
        .STAGES(SYNC_STAGES), .RESET_VAL(1'b1), .FALLING(1'b1)
    ) u_rx_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .edge_o(rx_fall)
    );

    assign restart = cfg_en & cfg_autobaud & rx_fall;
    assign clr     = ~cfg_en | restart;
    assign load    = clr | terminal;

    always_comb begin
        unique case (act_q.src)
            SRC_EXT_A: src_tick = ext_rise[0];
            SRC_EXT_B: src_tick = ext_rise[1];
            default:   src_tick = 1'b1;
        endcase
    end

    always_comb begin
        act_d = act_q;
        if (load) begin
            act_d.src = src_e'(cfg_src_sel);
            act_d.pre = cfg_pre16;
            act_d.div = cfg_div;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    assign act_src = act_q.src;
    assign act_pre = act_q.pre;
    assign act_div = act_q.div;

    bcg_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(clr), .pre_on(act_pre),
        .src_tick(src_tick), .pre_tick(pre_tick)
    );

    bcg_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(clr), .pre_tick(pre_tick),
        .div_val(act_div), .terminal(terminal),
        .clk_o(baud_clk_o), .tick_o(baud_tick_o)
    );
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
    parameter int DIV_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en,
    input logic             restart,
    input logic             load,
    input logic [1:0]       act_src,
    input logic             act_pre,
    input logic [DIV_W-1:0] act_div,
    input logic             baud_clk_o,
    input logic             baud_tick_o
);
    assert_disable_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (!baud_clk_o && !baud_tick_o));

    assert_tick_toggles_clk_R5: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick_o |-> (baud_clk_o != $past(baud_clk_o)));

    assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!baud_clk_o && !baud_tick_o));

    assert_settings_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(act_div) && $stable(act_pre) && $stable(act_src)));

    assert_prescaled_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_pre && baud_tick_o) |=> !baud_tick_o);
endmodule

bind baud_clkgen bcg_checker #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .restart(restart), .load(load),
    .act_src(act_src), .act_pre(act_pre), .act_div(act_div),
    .baud_clk_o(baud_clk_o), .baud_tick_o(baud_tick_o)
);

// File: tb/sim_baud_clkgen.sv
module sim_baud_clkgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic [1:0]  cfg_src_sel = 2'b00;
    logic        cfg_pre16 = 1'b0;
    logic [11:0] cfg_div = 12'd0;
    logic        cfg_autobaud = 1'b0;
    logic        rxd = 1'b1;
    logic        ext_clk_a = 1'b0;
    logic        ext_clk_b = 1'b0;
    logic        baud_clk_o, baud_tick_o;

    int    vectors = 0;
    int    fails = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string cur_req = "R10";

    always #4 clk = ~clk;

    baud_clkgen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_src_sel(cfg_src_sel),
        .cfg_pre16(cfg_pre16), .cfg_div(cfg_div), .cfg_autobaud(cfg_autobaud),
        .rxd(rxd), .ext_clk_a(ext_clk_a), .ext_clk_b(ext_clk_b),
        .baud_clk_o(baud_clk_o), .baud_tick_o(baud_tick_o)
    );

    // external clocks: A toggles every 3 cycles, B every 5
    initial forever begin repeat (3) @(negedge clk); ext_clk_a = ~ext_clk_a; end
    initial forever begin repeat (5) @(negedge clk); ext_clk_b = ~ext_clk_b; end

    // behavioural reference model
    bit qa[$], qb[$], qr[$];
    int m_pcnt, m_dcnt, m_src, m_div;
    bit m_pre, m_clk, m_tick;
    bit e_a, e_b, e_rx, src_t, rst_evt, p_t, term;

    always @(posedge clk) begin
        if (!rst_n) begin
            qa = '{0, 0, 0}; qb = '{0, 0, 0}; qr = '{1, 1, 1};
            m_pcnt = 0; m_dcnt = 0; m_src = 0; m_div = 0;
            m_pre = 0; m_clk = 0; m_tick = 0;
        end else begin
            e_a  = qa[1] && !qa[2];
            e_b  = qb[1] && !qb[2];
            e_rx = !qr[1] && qr[2];
            src_t = (m_src == 1) ? e_a : (m_src == 2) ? e_b : 1'b1;
            rst_evt = cfg_en && cfg_autobaud && e_rx;
            if (!cfg_en || rst_evt) begin
                m_pcnt = 0; m_dcnt = 0; m_clk = 0; m_tick = 0;
                m_src = cfg_src_sel; m_pre = cfg_pre16; m_div = cfg_div;
            end else begin
                p_t = src_t && (!m_pre || m_pcnt == 15);
                if (!m_pre) m_pcnt = 0;
                else if (src_t) m_pcnt = (m_pcnt + 1) % 16;
                term = p_t && (m_dcnt == m_div);
                if (p_t) m_dcnt = term ? 0 : m_dcnt + 1;
                m_tick = term;
                m_clk  = m_clk ^ term;
                if (term) begin
                    m_src = cfg_src_sel; m_pre = cfg_pre16; m_div = cfg_div;
                end
            end
            qa.push_front(ext_clk_a); void'(qa.pop_back());
            qb.push_front(ext_clk_b); void'(qb.pop_back());
            qr.push_front(rxd);       void'(qr.pop_back());
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (baud_clk_o !== m_clk || baud_tick_o !== m_tick) begin
                fails++;
                $display("FAIL %s: clk/tick actual %b/%b expected %b/%b at cycle %0d",
                         cur_req, baud_clk_o, baud_tick_o, m_clk, m_tick, cycles);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!baud_tick_o && n < 20000);
    endtask

    task automatic period(output int p);
        int skip;
        wait_tick(skip);
        wait_tick(p);
    endtask

    int p, n;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 clk", baud_clk_o, 0);
        chk("R10 tick", baud_tick_o, 0);

        // R3: division ratios from the internal reference
        cur_req = "R3"; cfg_en = 1'b1; cfg_div = 12'd5;
        period(p); chk("R3 div5", p, 6);
        cfg_div = 12'd0;
        period(p); chk("R3 div0", p, 1);
        cfg_div = 12'd4095;
        period(p); chk("R3 div4095", p, 4096);

        // R4: prescale by 16
        cur_req = "R4"; cfg_div = 12'd2; cfg_pre16 = 1'b1;
        period(p); chk("R4 pre16 div2", p, 48);
        cfg_pre16 = 1'b0;

        // R1 / R2: source selection and external edge ticks
        cur_req = "R2"; cfg_div = 12'd1; cfg_src_sel = 2'b01;
        period(p); period(p); chk("R2 ext A", p, 12);
        cfg_src_sel = 2'b10;
        period(p); period(p); chk("R1 ext B", p, 20);
        cur_req = "R1"; cfg_src_sel = 2'b11;
        period(p); period(p); chk("R1 ref alt", p, 2);
        cfg_src_sel = 2'b00;

        // R5: tick and clock relation (model compare on every cycle)
        cur_req = "R5"; cfg_div = 12'd3;
        period(p); chk("R5 half rate", p, 4);

        // R6: change mid-run takes effect at terminal count
        cur_req = "R6";
        wait_tick(n);
        cfg_div = 12'd9;
        wait_tick(n); chk("R6 old period kept", n, 4);
        wait_tick(n); chk("R6 new period", n, 10);

        // R7: autobaud restart
        cur_req = "R7"; cfg_div = 12'd20; cfg_autobaud = 1'b1;
        period(p);
        repeat (5) @(negedge clk);
        rxd = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 clk low", baud_clk_o, 0);
        chk("R7 no tick", baud_tick_o, 0);
        wait_tick(n); chk("R7 realigned", n, 21);
        rxd = 1'b1;
        repeat (4) @(negedge clk);

        // R8: rxd ignored with autobaud off
        cur_req = "R8"; cfg_autobaud = 1'b0;
        wait_tick(n);
        rxd = 1'b0;
        wait_tick(n); chk("R8 rxd ignored", n, 21);
        rxd = 1'b1;

        // R9: disable and re-enable
        cur_req = "R9"; cfg_en = 1'b0; cfg_div = 12'd7;
        @(negedge clk);
        chk("R9 clk low", baud_clk_o, 0);
        chk("R9 tick low", baud_tick_o, 0);
        repeat (3) @(negedge clk);
        cfg_en = 1'b1;
        wait_tick(n); chk("R9 first tick", n, 8);

        repeat (10) @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule